// File: doc/BRIEF.md
# Packed signed halving add/subtract unit

This block does packed-SIMD arithmetic on two 32-bit source words. It reads each word as signed integer lanes: two 16-bit halfword lanes or four 8-bit byte lanes. Every lane first sign-extends its two inputs by one bit and then adds or subtracts them, so the intermediate sum or difference is exact. That value is shifted right arithmetically by one bit, and the lane keeps the low lane-width bits. The halved result always fits in the lane, so no saturation and no status flags are needed.

A 3-bit selector chooses the lane width and the operation. Two of the halfword modes are exchange modes: they pair each half of the first operand with the opposite half of the second operand. The operation executes when the 4-bit condition code is the always-execute value, or when the external condition-pass input is high. The result and a write-enable are registered, with one cycle of latency after the valid strobe.

Top module: `phalf_unit`

## Requirements
- R1: Selector 0 (halfword add). For each halfword lane h at bits 16h+15:16h, the result lane is bits 16:1 of the 17-bit sum of the sign-extended A and B lanes.
- R2: Selector 3 (halfword subtract). Each halfword result lane is bits 16:1 of the 17-bit signed difference A lane minus B lane.
- R3: Selector 1 (add-subtract with exchange). The low result half is (A[15:0] − B[31:16]) halved. The high result half is (A[31:16] + B[15:0]) halved.
- R4: Selector 2 (subtract-add with exchange). The low result half is (A[15:0] + B[31:16]) halved. The high result half is (A[31:16] − B[15:0]) halved.
- R5: Selector 4 (byte add). Each of the four byte lanes at bits 8k+7:8k is computed on its own as the halved 9-bit signed sum, and the result goes back into the same byte position.
- R6: Selector 7 (byte subtract). Each byte lane is the halved 9-bit signed difference A byte minus B byte, in the same byte position.
- R7: Selectors 5 and 6 are reserved. When such an operation executes, out_we is 0 in the next cycle and out_result becomes 0.
- R8: Condition code 4'hE always executes, whatever the value of in_cond_pass.
- R9: Any other condition code executes only when in_cond_pass is 1. When the condition fails, out_we is 0 in the next cycle and out_result keeps its previous value.
- R10: out_result and out_we update at the first rising clock edge after in_valid is sampled high. In a cycle with in_valid low, out_we drops to 0 and out_result holds its value.
- R11: An active-low asynchronous reset clears out_we and out_result to 0.
- R12: The lane extremes produce no overflow: 0x7FFF+0x7FFF gives 0x7FFF, 0x8000−0x7FFF gives 0x8000, and 0xFFFF+0x0000 gives 0xFFFF. The 8-bit analogues 0x7F+0x7F, 0x80−0x7F and 0xFF+0x00 give 0x7F, 0x80 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_sel | input | 3 | Operation selector |
| in_cond | input | 4 | Condition code; 4'hE always executes |
| in_cond_pass | input | 1 | External condition-evaluation result |
| in_a | input | 32 | First source operand |
| in_b | input | 32 | Second source operand |
| out_result | output | 32 | Registered packed result |
| out_we | output | 1 | Registered destination write-enable |

## Verification
The assertions assume that in_valid, in_sel, in_cond and in_cond_pass are stable at every sampling edge. They also assume that outputs are judged only one cycle after an operation, with no back-to-back valid pulses overlapping the check. The bench changes inputs only on falling edges and sends one operation at a time, each followed by an idle cycle. This lets the hold-on-idle and hold-on-failed-condition properties see a clean prior value. Random operands, selectors and condition inputs come from a fixed seed. They are mixed with directed extreme-value lanes in every mode, so both carry-sensitive halving edges and the reserved codes are reached.

// File: rtl/phalf_pkg.sv
package phalf_pkg;

  typedef enum logic [2:0] {
    OP_ADD16 = 3'd0,
    OP_ASX   = 3'd1,
    OP_SAX   = 3'd2,
    OP_SUB16 = 3'd3,
    OP_ADD8  = 3'd4,
    OP_RSV5  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_SUB8  = 3'd7
  } op_e;

  localparam logic [3:0] COND_ALWAYS = 4'hE;

endpackage

// File: rtl/phalf_lane.sv
// One signed lane: widen by a bit, add or subtract, keep bits W:1.
module phalf_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] r
);
  logic [W:0] wx, wy, full;

  always_comb begin
    wx   = {x[W-1], x};
    wy   = {y[W-1], y};
    full = sub ? (wx - wy) : (wx + wy);
    r    = full[W:1];
  end
endmodule

// File: rtl/phalf_cond.sv
// Decides whether a strobed operation executes.
module phalf_cond
  import phalf_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] cond,
  input  logic       cond_pass,
  output logic       exec
);
  always_comb exec = valid && ((cond == COND_ALWAYS) || cond_pass);
endmodule

// File: rtl/phalf_datapath.sv
// Operand routing, halfword and byte lane arrays, and mode mux.
module phalf_datapath
  import phalf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              legal
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NHALF  = 2;
  localparam int NBYTE  = DATA_W / BYTE_W;

  op_e op;
  logic              xchg;
  logic [NHALF-1:0]  hsub;
  logic              bsub;
  logic [DATA_W-1:0] half_res, byte_res;

  always_comb begin
    op   = op_e'(sel);
    xchg = (op == OP_ASX) || (op == OP_SAX);
    bsub = (op == OP_SUB8);
    unique case (op)
      OP_SUB16: hsub = 2'b11;
      OP_ASX:   hsub = 2'b01;
      OP_SAX:   hsub = 2'b10;
      default:  hsub = 2'b00;
    endcase
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam int PEER = xchg_peer(h);
    logic [HALF_W-1:0] y_src;
    always_comb y_src = xchg ? b[PEER*HALF_W +: HALF_W] : b[h*HALF_W +: HALF_W];
    phalf_lane #(.W(HALF_W)) u_lane (
      .x   (a[h*HALF_W +: HALF_W]),
      .y   (y_src),
      .sub (hsub[h]),
      .r   (half_res[h*HALF_W +: HALF_W])
    );
  end

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    phalf_lane #(.W(BYTE_W)) u_lane (
      .x   (a[k*BYTE_W +: BYTE_W]),
      .y   (b[k*BYTE_W +: BYTE_W]),
      .sub (bsub),
      .r   (byte_res[k*BYTE_W +: BYTE_W])
    );
  end

  function automatic int xchg_peer(int h);
    return (NHALF - 1) - h;
  endfunction

  always_comb begin
    unique case (op)
      OP_ADD16, OP_ASX, OP_SAX, OP_SUB16: begin
        result = half_res;
        legal  = 1'b1;
      end
      OP_ADD8, OP_SUB8: begin
        result = byte_res;
        legal  = 1'b1;
      end
      default: begin
        result = '0;
        legal  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/phalf_unit.sv
// Top: condition gate, datapath, registered result and write-enable.
module phalf_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_sel,
  input  logic [3:0]        in_cond,
  input  logic              in_cond_pass,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic [DATA_W-1:0] out_result,
  output logic              out_we
);
  logic              exec;
  logic              dp_legal;
  logic [DATA_W-1:0] dp_result;
  logic [DATA_W-1:0] res_d;
  logic              res_en;
  logic              we_d;

  phalf_cond u_cond (
    .valid     (in_valid),
    .cond      (in_cond),
    .cond_pass (in_cond_pass),
    .exec      (exec)
  );

  phalf_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .sel    (in_sel),
    .a      (in_a),
    .b      (in_b),
    .result (dp_result),
    .legal  (dp_legal)
  );

  always_comb begin
    res_en = exec;
    res_d  = dp_legal ? dp_result : '0;
    we_d   = exec && dp_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_we     <= 1'b0;
      out_result <= '0;
    end else begin
      out_we <= we_d;
      if (res_en) out_result <= res_d;
    end
  end
endmodule

// File: rtl/phalf_unit_chk.sv
module phalf_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  in_sel,
  input logic [3:0]  in_cond,
  input logic        in_cond_pass,
  input logic [31:0] out_result,
  input logic        out_we
);
  logic rsv, cok;
  always_comb begin
    rsv = (in_sel == 3'd5) || (in_sel == 3'd6);
    cok = (in_cond == 4'hE) || in_cond_pass;
  end

  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cok && rsv) |=> (!out_we && out_result == 32'd0));

  assert_always_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cond == 4'hE && !rsv) |=> out_we);

  assert_cond_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cond != 4'hE && !in_cond_pass) |=> (!out_we && $stable(out_result)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> (!out_we && $stable(out_result)));
endmodule

bind phalf_unit phalf_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_sel       (in_sel),
  .in_cond      (in_cond),
  .in_cond_pass (in_cond_pass),
  .out_result   (out_result),
  .out_we       (out_we)
);

// File: tb/phalf_unit_test.sv
`timescale 1ns/1ps
module phalf_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_sel;
  logic [3:0]  in_cond;
  logic        in_cond_pass;
  logic [31:0] in_a, in_b;
  logic [31:0] out_result;
  logic        out_we;

  int checks = 0;
  int errors = 0;
  logic [31:0] held;
  bit done = 0;

  always #2.5 clk = ~clk;

  phalf_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
    .in_cond(in_cond), .in_cond_pass(in_cond_pass), .in_a(in_a), .in_b(in_b),
    .out_result(out_result), .out_we(out_we)
  );

  function automatic int sx16(logic [31:0] v, int h);
    logic [15:0] t;
    t = v[h*16 +: 16];
    return int'($signed(t));
  endfunction

  function automatic int sx8(logic [31:0] v, int k);
    logic [7:0] t;
    t = v[k*8 +: 8];
    return int'($signed(t));
  endfunction

  function automatic logic [31:0] model(logic [2:0] s, logic [31:0] a, logic [31:0] b);
    logic [31:0] o;
    int lo, hi, r;
    o = '0;
    case (s)
      3'd0: begin lo = sx16(a,0) + sx16(b,0); hi = sx16(a,1) + sx16(b,1); end
      3'd1: begin lo = sx16(a,0) - sx16(b,1); hi = sx16(a,1) + sx16(b,0); end
      3'd2: begin lo = sx16(a,0) + sx16(b,1); hi = sx16(a,1) - sx16(b,0); end
      3'd3: begin lo = sx16(a,0) - sx16(b,0); hi = sx16(a,1) - sx16(b,1); end
      default: begin lo = 0; hi = 0; end
    endcase
    if (s <= 3'd3) begin
      lo = lo >>> 1; hi = hi >>> 1;
      o = {hi[15:0], lo[15:0]};
    end else if (s == 3'd4 || s == 3'd7) begin
      for (int k = 0; k < 4; k++) begin
        r = (s == 3'd4) ? sx8(a,k) + sx8(b,k) : sx8(a,k) - sx8(b,k);
        r = r >>> 1;
        o[k*8 +: 8] = r[7:0];
      end
    end
    return o;
  endfunction

  function automatic string req_of(logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd3: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R5";
      3'd7: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] s, input logic [3:0] c, input logic p,
                        input logic [31:0] a, input logic [31:0] b, input string req);
    bit ex, lg;
    logic [31:0] exp_res;
    logic exp_we;
    @(negedge clk);
    in_valid = 1'b1; in_sel = s; in_cond = c; in_cond_pass = p; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    ex = (c == 4'hE) || p;
    lg = !(s == 3'd5 || s == 3'd6);
    exp_we = ex && lg;
    if (ex) held = lg ? model(s, a, b) : 32'd0;
    exp_res = held;
    check({req, " we"}, {31'd0, out_we}, {31'd0, exp_we});
    check({req, " result"}, out_result, exp_res);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    logic [2:0]  rs;
    logic [3:0]  rc;
    logic        rp;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_sel = '0; in_cond = 4'hE;
    in_cond_pass = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 we", {31'd0, out_we}, 32'd0);
    check("R11 result", out_result, 32'd0);
    rst_n = 1'b1;
    held = 32'd0;

    // R12 extreme lanes in every mode
    for (int m = 0; m < 8; m++) begin
      run_op(m[2:0], 4'hE, 1'b0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, {req_of(m[2:0]), " R12 max"});
      run_op(m[2:0], 4'hE, 1'b0, 32'h8000_8000, 32'h7FFF_7FFF, {req_of(m[2:0]), " R12 min"});
      run_op(m[2:0], 4'hE, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, {req_of(m[2:0]), " R12 neg1"});
      run_op(m[2:0], 4'hE, 1'b0, 32'h8000_7FFF, 32'h7FFF_8000, {req_of(m[2:0]), " R12 mix"});
    end
    // R12 explicit expected values
    run_op(3'd0, 4'hE, 1'b0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, "R12");
    check("R12 add16 max", out_result, 32'h7FFF_7FFF);
    run_op(3'd3, 4'hE, 1'b0, 32'h8000_8000, 32'h7FFF_7FFF, "R12");
    check("R12 sub16 min", out_result, 32'h8000_8000);
    run_op(3'd4, 4'hE, 1'b0, 32'hFF7F_FF7F, 32'h007F_007F, "R12");
    check("R12 add8", out_result, 32'hFF7F_FF7F);
    run_op(3'd7, 4'hE, 1'b0, 32'h8080_8080, 32'h7F7F_7F7F, "R12");
    check("R12 sub8", out_result, 32'h8080_8080);
    // R3/R4 exchange visible: distinct halves
    run_op(3'd1, 4'hE, 1'b0, 32'h0010_0100, 32'h0002_0040, "R3");
    check("R3 exchange", out_result, 32'h0028_007F);
    run_op(3'd2, 4'hE, 1'b0, 32'h0010_0100, 32'h0002_0040, "R4");
    check("R4 exchange", out_result, 32'hFFE8_0081);

    // R8 always condition with pass low; R9 failed condition holds result
    run_op(3'd0, 4'hE, 1'b0, 32'h0004_0006, 32'h0002_0002, "R8");
    run_op(3'd0, 4'h3, 1'b0, 32'h1234_5678, 32'h1111_1111, "R9 fail");
    check("R9 hold", out_result, 32'h0003_0004);
    run_op(3'd3, 4'h3, 1'b1, 32'h1234_5678, 32'h1111_1111, "R9 pass");
    // R7 reserved after a nonzero result
    run_op(3'd5, 4'h0, 1'b1, 32'hAAAA_5555, 32'h1234_4321, "R7 sel5");
    run_op(3'd0, 4'hE, 1'b0, 32'h0100_0100, 32'h0100_0100, "R1");
    run_op(3'd6, 4'hE, 1'b0, 32'hAAAA_5555, 32'h1234_4321, "R7 sel6");
    // R10 idle cycle: inputs change, valid low
    run_op(3'd4, 4'hE, 1'b0, 32'h1020_3040, 32'h0102_0304, "R5");
    @(negedge clk);
    in_a = 32'hDEAD_BEEF; in_b = 32'h1357_9BDF; in_sel = 3'd3;
    @(negedge clk);
    check("R10 idle we", {31'd0, out_we}, 32'd0);
    check("R10 idle result", out_result, held);

    // random mix
    for (int i = 0; i < 600; i++) begin
      ra = $urandom; rb = $urandom; rs = 3'($urandom);
      rc = 4'($urandom); rp = 1'($urandom);
      if ($urandom % 3 == 0) rc = 4'hE;
      run_op(rs, rc, rp, ra, rb, {req_of(rs), (rc == 4'hE) ? " R8" : " R9"});
    end

    // R11 asynchronous reset mid-run
    run_op(3'd0, 4'hE, 1'b0, 32'h4000_4000, 32'h2000_2000, "R1");
    #1.2 rst_n = 1'b0;
    #0.5;
    check("R11 async we", {31'd0, out_we}, 32'd0);
    check("R11 async result", out_result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule